// File: doc/BRIEF.md
# SDRAM Column Burst Address Generator

This block turns one column command into the run of column addresses that a burst touches, one address per clock. A command carries a 10-bit starting column and a read/write flag. The burst is 4 or 8 beats long. Every beat stays inside the aligned group of 4 or 8 columns that holds the starting column, so the page of 1024 columns is never crossed. The order inside the group is either sequential, which counts up and wraps, or interleaved, which XORs the beat number into the low column bits.

A command that arrives while a burst is running is checked against the interruption rules. If the command is legal, the burst restarts at the new column on the next cycle. If it is illegal, the command is dropped, the running burst carries on unchanged, and a one-cycle error pulse is raised. The burst-length and ordering settings are captured only when a command starts from idle. A burst that follows on from another one keeps the settings it was started with.

Top module: `col_burst_gen`

## Requirements
- R1: After reset, `addr_valid`, `last_beat` and `cmd_err` are 0. A command accepted while idle makes `addr_valid` rise on the next cycle. `addr_valid` then stays high for exactly BL cycles, where BL is 4 when `cfg_long_burst`=0 and 8 when `cfg_long_burst`=1. `last_beat` is high only on the final beat, and `addr_valid` falls on the cycle after it unless a new burst was accepted.
- R2: Every address of a burst keeps the starting column's bits above the group offset. These are bits [9:2] for BL4 and bits [9:3] for BL8.
- R3: The first beat outputs the supplied column unchanged. `addr_is_wr` follows the command's `cmd_is_wr` for the whole burst.
- R4: With `cfg_interleave`=0 (sequential), the offset of beat k is (s + k) mod BL, where s is the starting column mod BL.
- R5: With `cfg_interleave`=1 (interleaved), the offset of beat k is s XOR k.
- R6: In BL4, a command that arrives before the last beat is rejected. `cmd_err` is 1 for exactly the next cycle, and the running burst continues with no change to its addresses.
- R7: In BL8, a command of the same direction that arrives during beat 3 is accepted. The next cycle outputs beat 0 of the new burst. A command of the opposite direction at beat 3 is rejected, as is any command at beats 0–2 or 4–6.
- R8: A command that arrives during the final beat of a burst is accepted in either direction. The new burst follows with no gap.
- R9: A command in the cycle right after an accepted command is rejected with `cmd_err` (minimum 2-cycle command spacing).
- R10: Changes to `cfg_long_burst` or `cfg_interleave` while a burst runs have no effect on that burst. They also have no effect on a burst that continues from it. They are taken only when a command starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_is_wr | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | 10 | Starting column of the command |
| cfg_long_burst | input | 1 | 0 = BL4, 1 = BL8 (captured when idle) |
| cfg_interleave | input | 1 | 0 = sequential, 1 = interleaved (captured when idle) |
| addr_valid | output | 1 | `col_addr` holds a burst beat |
| col_addr | output | 10 | Column address of the current beat |
| addr_is_wr | output | 1 | Direction of the running burst |
| last_beat | output | 1 | Current beat is the final one of the burst |
| cmd_err | output | 1 | One-cycle pulse after a rejected command |

## Verification
On every cycle, assertions check three things: an accepted command shows its own column on the next cycle; consecutive beats never leave their aligned group; and the final beat ends the burst. They also check that a rejected command leaves the beat counter and starting column advancing untouched, and that accepted commands are never adjacent. Only the bench's scenarios can show the exact beat order. The bench sweeps every starting offset in both orderings and both burst lengths. The scenarios also cover which interruption points and directions are accepted, and that settings changed in mid-burst are ignored.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef struct packed {
    logic   is_wr;
    logic   bl_long;
    order_e order;
  } burst_ctx_t;
endpackage

// File: rtl/cbg_addr.sv
module cbg_addr #(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BEAT_W = 3
) (
  input  logic [COL_W-1:0]  start_col,
  input  logic [BEAT_W-1:0] beat,
  input  logic              bl_long,
  input  cbg_pkg::order_e   order,
  output logic [COL_W-1:0]  col
);
  logic [BEAT_W-1:0] seq_off;
  logic [BEAT_W-1:0] ilv_off;

  always_comb begin
    seq_off = start_col[BEAT_W-1:0] + beat;
    ilv_off = start_col[BEAT_W-1:0] ^ beat;
  end

  assign col[COL_W-1:BEAT_W] = start_col[COL_W-1:BEAT_W];

  for (genvar i = 0; i < BEAT_W; i++) begin : g_off
    if (i < BEAT_W - 1) begin : g_always_in
      assign col[i] = (order == cbg_pkg::ORD_ILV) ? ilv_off[i] : seq_off[i];
    end else begin : g_top_bit
      assign col[i] = !bl_long ? start_col[i] :
                      (order == cbg_pkg::ORD_ILV) ? ilv_off[i] : seq_off[i];
    end
  end
endmodule

// File: rtl/cbg_legal.sv
module cbg_legal #(
  parameter int unsigned BEAT_W = 3
) (
  input  logic              cmd_valid,
  input  logic              cmd_is_wr,
  input  logic              active,
  input  logic [BEAT_W-1:0] beat,
  input  logic              cur_is_wr,
  input  logic              bl_long,
  input  logic              prev_acc,
  output logic              accept,
  output logic              reject
);
  localparam int unsigned    HALF      = (1 << BEAT_W) / 2;
  localparam logic [BEAT_W-1:0] LAST_LONG = BEAT_W'((1 << BEAT_W) - 1);
  localparam logic [BEAT_W-1:0] LAST_SHRT = BEAT_W'(HALF - 1);

  logic on_last;
  logic on_half;
  logic ok;

  always_comb begin
    on_last = bl_long ? (beat == LAST_LONG) : (beat == LAST_SHRT);
    on_half = bl_long && (beat == LAST_SHRT) && (cmd_is_wr == cur_is_wr);
    if (prev_acc)    ok = 1'b0;
    else if (!active) ok = 1'b1;
    else             ok = on_last || on_half;
    accept = cmd_valid && ok;
    reject = cmd_valid && !ok;
  end
endmodule

// File: rtl/cbg_seq.sv
module cbg_seq #(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BEAT_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                reject,
  input  logic [COL_W-1:0]    cmd_col,
  input  logic                cmd_is_wr,
  input  logic                cfg_bl_long,
  input  cbg_pkg::order_e     cfg_order,
  output logic                active,
  output logic [BEAT_W-1:0]   beat,
  output logic [COL_W-1:0]    start_col,
  output cbg_pkg::burst_ctx_t ctx,
  output logic                prev_acc,
  output logic                err,
  output logic                on_last
);
  localparam logic [BEAT_W-1:0] LAST_LONG = BEAT_W'((1 << BEAT_W) - 1);
  localparam logic [BEAT_W-1:0] LAST_SHRT = BEAT_W'((1 << BEAT_W) / 2 - 1);

  logic                active_d;
  logic [BEAT_W-1:0]   beat_d;
  logic [COL_W-1:0]    start_d;
  cbg_pkg::burst_ctx_t ctx_d;
  logic                start_en;

  always_comb begin
    on_last  = active && (ctx.bl_long ? (beat == LAST_LONG) : (beat == LAST_SHRT));
    start_en = accept;
    active_d = active;
    beat_d   = beat;
    start_d  = start_col;
    ctx_d    = ctx;
    if (accept) begin
      active_d    = 1'b1;
      beat_d      = '0;
      start_d     = cmd_col;
      ctx_d.is_wr = cmd_is_wr;
      if (!active) begin
        ctx_d.bl_long = cfg_bl_long;
        ctx_d.order   = cfg_order;
      end
    end else if (active) begin
      if (on_last) begin
        active_d = 1'b0;
        beat_d   = '0;
      end else begin
        beat_d = beat + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat     <= '0;
      prev_acc <= 1'b0;
      err      <= 1'b0;
    end else begin
      active   <= active_d;
      beat     <= beat_d;
      prev_acc <= accept;
      err      <= reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_col <= '0;
      ctx       <= '0;
    end else if (start_en) begin
      start_col <= start_d;
      ctx       <= ctx_d;
    end
  end

  // R6: a dropped command leaves a running burst stepping on unchanged
  p_reject_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && active && !on_last) |=>
      (active && beat == $past(beat) + 1'b1 && start_col == $past(start_col)));

  // R1: final beat without a new command ends the burst
  p_last_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (on_last && !accept) |=> !active);
endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen #(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BEAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_is_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cfg_long_burst,
  input  logic             cfg_interleave,
  output logic             addr_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             addr_is_wr,
  output logic             last_beat,
  output logic             cmd_err
);
  logic                active;
  logic [BEAT_W-1:0]   beat;
  logic [COL_W-1:0]    start_col;
  cbg_pkg::burst_ctx_t ctx;
  logic                prev_acc;
  logic                accept;
  logic                reject;
  logic                on_last;
  cbg_pkg::order_e     cfg_order;

  assign cfg_order = cfg_interleave ? cbg_pkg::ORD_ILV : cbg_pkg::ORD_SEQ;

  cbg_legal #(.BEAT_W(BEAT_W)) u_legal (
    .cmd_valid (cmd_valid),
    .cmd_is_wr (cmd_is_wr),
    .active    (active),
    .beat      (beat),
    .cur_is_wr (ctx.is_wr),
    .bl_long   (ctx.bl_long),
    .prev_acc  (prev_acc),
    .accept    (accept),
    .reject    (reject)
  );

  cbg_seq #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .reject      (reject),
    .cmd_col     (cmd_col),
    .cmd_is_wr   (cmd_is_wr),
    .cfg_bl_long (cfg_long_burst),
    .cfg_order   (cfg_order),
    .active      (active),
    .beat        (beat),
    .start_col   (start_col),
    .ctx         (ctx),
    .prev_acc    (prev_acc),
    .err         (cmd_err),
    .on_last     (on_last)
  );

  cbg_addr #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_addr (
    .start_col (start_col),
    .beat      (beat),
    .bl_long   (ctx.bl_long),
    .order     (ctx.order),
    .col       (col_addr)
  );

  assign addr_valid = active;
  assign addr_is_wr = ctx.is_wr;
  assign last_beat  = on_last;

  // R3: an accepted command shows its own column first
  p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (addr_valid && col_addr == $past(cmd_col) && addr_is_wr == $past(cmd_is_wr)));

  // R2: consecutive beats of one burst stay in the aligned group
  p_in_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid) && !$past(accept)) |->
      ((col_addr >> (ctx.bl_long ? BEAT_W : BEAT_W - 1)) ==
       ($past(col_addr) >> (ctx.bl_long ? BEAT_W : BEAT_W - 1))));

  // R9: accepted commands are at least two cycles apart
  p_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  // R6: every refused command gives one error pulse
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !accept) |=> cmd_err);
endmodule

// File: tb/sim_col_burst_gen.sv
module sim_col_burst_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_is_wr, cfg_long_burst, cfg_interleave;
  logic [9:0] cmd_col;
  logic       addr_valid, addr_is_wr, last_beat, cmd_err;
  logic [9:0] col_addr;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  col_burst_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cmd_col(cmd_col), .cfg_long_burst(cfg_long_burst), .cfg_interleave(cfg_interleave),
    .addr_valid(addr_valid), .col_addr(col_addr), .addr_is_wr(addr_is_wr),
    .last_beat(last_beat), .cmd_err(cmd_err)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_col(int s, int k, bit bl8, bit ilv);
    int bl  = bl8 ? 8 : 4;
    int low = s % bl;
    int off = ilv ? (low ^ k) : ((low + k) % bl);
    return s - low + off;
  endfunction

  // drive a command on this negedge; returns at next negedge (beat 0 visible)
  task automatic issue(int col, bit wr);
    cmd_valid = 1'b1; cmd_col = 10'(col); cmd_is_wr = wr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_beat(int s, int k, bit bl8, bit ilv, bit wr);
    int bl = bl8 ? 8 : 4;
    check("R1 addr_valid", addr_valid, 1);
    check(ilv ? "R5 interleaved col" : "R4 sequential col", col_addr, exp_col(s, k, bl8, ilv));
    if (k == 0) check("R3 first col", col_addr, s);
    check("R2 group", col_addr / bl, s / bl);
    check("R3 direction", addr_is_wr, wr);
    check("R1 last_beat", last_beat, (k == bl - 1) ? 1 : 0);
    check("R6 no err", cmd_err, 0);
  endtask

  task automatic run_burst(int s, bit wr, bit bl8, bit ilv);
    int bl = bl8 ? 8 : 4;
    cfg_long_burst = bl8; cfg_interleave = ilv;
    issue(s, wr);
    for (int k = 0; k < bl; k++) begin
      check_beat(s, k, bl8, ilv, wr);
      @(negedge clk);
    end
    check("R1 idle after burst", addr_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 0; cmd_is_wr = 0; cmd_col = '0;
    cfg_long_burst = 0; cfg_interleave = 0;
    repeat (3) @(negedge clk);
    check("R1 reset addr_valid", addr_valid, 0);
    check("R1 reset last_beat", last_beat, 0);
    check("R1 reset cmd_err", cmd_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R2: sweep offsets, lengths, orders, several page positions
    for (int b = 0; b < 3; b++)
      for (int o = 0; o < 8; o++)
        for (int m = 0; m < 4; m++)
          run_burst((b == 0 ? 0 : b == 1 ? 344 : 1016) + o, m[0], m[1], m[0] ^ m[1]);
    for (int o = 0; o < 8; o++) begin
      run_burst(512 + o, 1'b0, 1'b1, 1'b1);
      run_burst(512 + o, 1'b1, 1'b0, 1'b1);
    end

    // R6: BL4, command at beat 1 rejected, burst continues
    cfg_long_burst = 0; cfg_interleave = 0;
    issue(101, 0);
    check_beat(101, 0, 0, 0, 0); @(negedge clk);
    check_beat(101, 1, 0, 0, 0);
    issue(200, 0);
    check("R6 err pulse", cmd_err, 1);
    check("R6 col unchanged", col_addr, exp_col(101, 2, 0, 0));
    @(negedge clk);
    check_beat(101, 3, 0, 0, 0); @(negedge clk);
    check("R6 burst ended", addr_valid, 0);

    // R9: command right after accepted one
    issue(40, 1);
    issue(80, 1);
    check("R9 err pulse", cmd_err, 1);
    check("R9 first burst kept", col_addr, exp_col(40, 1, 0, 0));
    repeat (3) @(negedge clk);

    // R7: BL8 same-direction interrupt at beat 3, with R10 cfg change mid-burst
    cfg_long_burst = 1; cfg_interleave = 1;
    issue(13, 0);
    cfg_long_burst = 0; cfg_interleave = 0;
    for (int k = 0; k < 3; k++) begin check_beat(13, k, 1, 1, 0); @(negedge clk); end
    check_beat(13, 3, 1, 1, 0);
    issue(250, 0);
    for (int k = 0; k < 8; k++) begin
      check_beat(250, k, 1, 1, 0);  // R7 restart, R10 kept BL8 interleaved
      @(negedge clk);
    end
    check("R7 idle", addr_valid, 0);

    // R7: opposite direction at beat 3 rejected
    cfg_long_burst = 1; cfg_interleave = 0;
    issue(66, 1);
    for (int k = 0; k < 3; k++) begin check_beat(66, k, 1, 0, 1); @(negedge clk); end
    check_beat(66, 3, 1, 0, 1);
    issue(300, 0);
    check("R7 opposite err", cmd_err, 1);
    check("R7 opposite ignored", col_addr, exp_col(66, 4, 1, 0));
    @(negedge clk);
    // R7: same direction at beat 5 rejected
    issue(300, 1);
    check("R7 beat5 err", cmd_err, 1);
    check("R7 beat5 ignored", col_addr, exp_col(66, 6, 1, 0));
    @(negedge clk);
    check_beat(66, 7, 1, 0, 1);

    // R8: seamless opposite-direction command on last beat; R10 cfg kept
    cfg_long_burst = 0; cfg_interleave = 1;
    issue(7, 0);
    for (int k = 0; k < 8; k++) begin
      check_beat(7, k, 1, 0, 0);  // R8 seamless, R10 still BL8 sequential
      @(negedge clk);
    end
    check("R8 idle", addr_valid, 0);

    // R10: cfg flip during BL4 burst has no effect
    cfg_long_burst = 0; cfg_interleave = 0;
    issue(2, 1);
    cfg_long_burst = 1; cfg_interleave = 1;
    for (int k = 0; k < 4; k++) begin check_beat(2, k, 0, 0, 1); @(negedge clk); end
    check("R10 burst length kept", addr_valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule